// File: doc/BRIEF.md
# Four-Segment Hybrid Final Adder

This block is the closing carry-propagate adder of a sum-of-products datapath. The two operands come out of a partial-product reduction tree. Their low-order bits settle early, the middle bits settle last, and the top bits settle somewhat sooner than the middle. The adder therefore uses a different carry structure in each of four adjacent bit ranges.

From the least significant bit upward, the segments are:

- a ripple-carry chain;
- a Kogge-Stone parallel-prefix adder;
- two carry-select stages, each holding two Brent-Kung prefix adders.

The carry out of each segment is the carry in of the segment above it.

The width of the ripple chain is a parameter. The other three widths are derived during elaboration from the bits that remain above the ripple chain. The block is purely combinational and has no clock or reset.

Top module: `hyb_final_adder`

## Requirements
- R1: For the default configuration (N=32, W1=7), `{c_out, sum_out}` equals the unsigned sum `a_in + b_in + c_in` for every input pattern.
- R2: Let r = N − W1. The prefix-segment width is r when r ≤ 8, and otherwise it is the largest power of two not above r. Call the bits left over after that m. The lower select segment takes floor(m/2) bits and the upper select segment takes the rest. For N=32 and W1=7 this gives 16, 4 and 5. For N=20 and W1=1 it gives 16, 1 and 2. For N=8 and W1=3 it gives 5, 0 and 0.
- R3: A carry entering at bit 0 travels through every segment boundary. With all operand-A bits set, operand B zero and carry-in 1, the sum is zero and the carry-out is 1. At each segment boundary, the internal carry equals the carry of the plain addition of the bits below that boundary.
- R4: With complementary alternating operands (A bits 0xAAAAAAAA, B bits 0x55555555), every bit only propagates. Carry-in 0 then gives an all-ones sum with carry-out 0, and carry-in 1 gives a zero sum with carry-out 1.
- R5: Each select segment outputs the precomputed result whose assumed carry matches the carry arriving from below. A carry that stops just under a select segment, and one that crosses into it, both give the correct sum.
- R6: A segment with zero width is left out. The carry passes straight through it, and the carry-out comes from the highest segment present. This is checked for N=8, W1=3 and for N=16, W1=0.
- R7: When W1 = N, the whole adder is the ripple chain and still adds correctly (N=12).
- R8: A configuration with a one-bit lower select segment (N=20, W1=1) adds correctly.
- R9: Zero operands with carry-in 0 give a zero sum and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | N | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The checker's immediate assertions take for granted that the operands and the carry-in are all known. It skips any evaluation in which an input is X or Z. The bench drives every input from time zero onward and only ever gives them fully defined values, so the boundary-carry and sum comparisons always apply. The checker also assumes N stays small enough for an N+1-bit reference addition. Every configuration the bench builds is 32 bits wide or less.

// File: rtl/hyb_add_pkg.sv
package hyb_add_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic gp_t gp_join(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic int floor_pow2(int v);
        int q;
        q = 1;
        for (int k = 0; k < 30; k++)
            if ((q * 2) <= v) q = q * 2;
        return q;
    endfunction

    function automatic int ks_width(int n, int w1);
        int r;
        r = n - w1;
        if (r <= 8) return r;
        return floor_pow2(r);
    endfunction

    function automatic int cs_lo_width(int n, int w1);
        return (n - w1 - ks_width(n, w1)) / 2;
    endfunction

    function automatic int cs_hi_width(int n, int w1);
        return n - w1 - ks_width(n, w1) - cs_lo_width(n, w1);
    endfunction

endpackage

// File: rtl/hyb_ripple_seg.sv
module hyb_ripple_seg #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic run_c;

    always_comb begin
        run_c = ci;
        for (int i = 0; i < W; i++) begin
            s[i]  = a[i] ^ b[i] ^ run_c;
            run_c = (a[i] & b[i]) | (run_c & (a[i] ^ b[i]));
        end
        co = run_c;
    end
endmodule

// File: rtl/hyb_ks_seg.sv
module hyb_ks_seg import hyb_add_pkg::*; #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;

    gp_t        pre [W];
    logic [W-1:0] bp;

    always_comb begin
        bp = a ^ b;
        for (int i = 0; i < W; i++) begin
            pre[i].g = a[i] & b[i];
            pre[i].p = bp[i];
        end
        // one row per level; walking down keeps the lower operand at this level's input value
        for (int lv = 0; lv < LEVELS; lv++)
            for (int i = W - 1; i >= (1 << lv); i--)
                pre[i] = gp_join(pre[i], pre[i - (1 << lv)]);
        s[0] = bp[0] ^ ci;
        for (int i = 1; i < W; i++)
            s[i] = bp[i] ^ (pre[i-1].g | (pre[i-1].p & ci));
        co = pre[W-1].g | (pre[W-1].p & ci);
    end
endmodule

// File: rtl/hyb_bk_core.sv
module hyb_bk_core import hyb_add_pkg::*; #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int TOP = floor_pow2(W);

    gp_t        pre [W];
    logic [W-1:0] bp;

    always_comb begin
        bp = a ^ b;
        for (int i = 0; i < W; i++) begin
            pre[i].g = a[i] & b[i];
            pre[i].p = bp[i];
        end
        // up-sweep builds power-of-two groups
        for (int d = 1; d < W; d = d * 2)
            for (int i = 2 * d - 1; i < W; i = i + 2 * d)
                pre[i] = gp_join(pre[i], pre[i - d]);
        // down-sweep fills the remaining positions
        for (int d = TOP; d >= 1; d = d / 2)
            for (int i = 3 * d - 1; i < W; i = i + 2 * d)
                pre[i] = gp_join(pre[i], pre[i - d]);
        s[0] = bp[0] ^ ci;
        for (int i = 1; i < W; i++)
            s[i] = bp[i] ^ (pre[i-1].g | (pre[i-1].p & ci));
        co = pre[W-1].g | (pre[W-1].p & ci);
    end
endmodule

// File: rtl/hyb_csel_seg.sv
module hyb_csel_seg #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_zero, s_one;
    logic         c_zero, c_one;

    hyb_bk_core #(.W(W)) u_bk0 (.a(a), .b(b), .ci(1'b0), .s(s_zero), .co(c_zero));
    hyb_bk_core #(.W(W)) u_bk1 (.a(a), .b(b), .ci(1'b1), .s(s_one),  .co(c_one));

    always_comb begin
        s  = ci ? s_one : s_zero;
        co = ci ? c_one : c_zero;
    end
endmodule

// File: rtl/hyb_final_adder.sv
module hyb_final_adder import hyb_add_pkg::*; #(
    parameter int N  = 32,
    parameter int W1 = 7
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         c_in,
    output logic [N-1:0] sum_out,
    output logic         c_out
);
    localparam int W2 = ks_width(N, W1);
    localparam int W3 = cs_lo_width(N, W1);
    localparam int W4 = cs_hi_width(N, W1);
    localparam int O2 = W1;
    localparam int O3 = W1 + W2;
    localparam int O4 = O3 + W3;

    logic cb1, cb2, cb3, cb4;

    generate
        if (W1 > 0) begin : g_rip
            hyb_ripple_seg #(.W(W1)) u_rip (
                .a(a_in[O2-1:0]), .b(b_in[O2-1:0]), .ci(c_in),
                .s(sum_out[O2-1:0]), .co(cb1));
        end else begin : g_rip_none
            assign cb1 = c_in;
        end

        if (W2 > 0) begin : g_ks
            hyb_ks_seg #(.W(W2)) u_ks (
                .a(a_in[O3-1:O2]), .b(b_in[O3-1:O2]), .ci(cb1),
                .s(sum_out[O3-1:O2]), .co(cb2));
        end else begin : g_ks_none
            assign cb2 = cb1;
        end

        if (W3 > 0) begin : g_cs_lo
            hyb_csel_seg #(.W(W3)) u_cs_lo (
                .a(a_in[O4-1:O3]), .b(b_in[O4-1:O3]), .ci(cb2),
                .s(sum_out[O4-1:O3]), .co(cb3));
        end else begin : g_cs_lo_none
            assign cb3 = cb2;
        end

        if (W4 > 0) begin : g_cs_hi
            hyb_csel_seg #(.W(W4)) u_cs_hi (
                .a(a_in[N-1:O4]), .b(b_in[N-1:O4]), .ci(cb3),
                .s(sum_out[N-1:O4]), .co(cb4));
        end else begin : g_cs_hi_none
            assign cb4 = cb3;
        end
    endgenerate

    assign c_out = cb4;
endmodule

// File: rtl/hyb_final_adder_chk.sv
module hyb_final_adder_chk import hyb_add_pkg::*; #(
    parameter int N  = 32,
    parameter int W1 = 7
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         ci,
    input logic [N-1:0] sum,
    input logic         co,
    input logic         cb1,
    input logic         cb2,
    input logic         cb3
);
    localparam int O3 = W1 + ks_width(N, W1);
    localparam int O4 = O3 + cs_lo_width(N, W1);

    function automatic logic carry_at(int k);
        logic [N:0] mask;
        logic [N:0] full;
        mask = '0;
        for (int j = 0; j < N; j++)
            if (j < k) mask[j] = 1'b1;
        full = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{N{1'b0}}, ci};
        return full[k];
    endfunction

    always_comb begin
        if (!$isunknown({a, b, ci})) begin
            // R1 full result against a reference addition
            a_r1_sum_matches: assert ({co, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci}));
            // R3 carry at each segment boundary
            a_r3_carry_after_ripple: assert (cb1 == carry_at(W1));
            a_r3_carry_after_prefix: assert (cb2 == carry_at(O3));
            a_r3_carry_after_sel_lo: assert (cb3 == carry_at(O4));
            // R6 carry-out equals the last boundary carry when the top segment is empty
            if (O4 == N) begin
                a_r6_pass_through: assert (co == cb3);
            end
        end
    end
endmodule

bind hyb_final_adder hyb_final_adder_chk #(.N(N), .W1(W1)) u_chk (
    .a(a_in), .b(b_in), .ci(c_in), .sum(sum_out), .co(c_out),
    .cb1(cb1), .cb2(cb2), .cb3(cb3));

// File: tb/hyb_final_adder_test.sv
module hyb_final_adder_test;
    import hyb_add_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] ta = '0, tb = '0;
    logic        tc = 1'b0;

    logic [31:0] s_main; logic c_main;
    logic [7:0]  s_ks;   logic c_ks;
    logic [15:0] s_pw;   logic c_pw;
    logic [19:0] s_odd;  logic c_odd;
    logic [11:0] s_rip;  logic c_rip;

    hyb_final_adder #(.N(32), .W1(7))  uut     (.a_in(ta),        .b_in(tb),        .c_in(tc), .sum_out(s_main), .c_out(c_main));
    hyb_final_adder #(.N(8),  .W1(3))  uut_ks  (.a_in(ta[7:0]),   .b_in(tb[7:0]),   .c_in(tc), .sum_out(s_ks),   .c_out(c_ks));
    hyb_final_adder #(.N(16), .W1(0))  uut_pw  (.a_in(ta[15:0]),  .b_in(tb[15:0]),  .c_in(tc), .sum_out(s_pw),   .c_out(c_pw));
    hyb_final_adder #(.N(20), .W1(1))  uut_odd (.a_in(ta[19:0]),  .b_in(tb[19:0]),  .c_in(tc), .sum_out(s_odd),  .c_out(c_odd));
    hyb_final_adder #(.N(12), .W1(12)) uut_rip (.a_in(ta[11:0]),  .b_in(tb[11:0]),  .c_in(tc), .sum_out(s_rip),  .c_out(c_rip));

    localparam int NV = 10;
    localparam logic [64:0] VEC [NV] = '{
        {32'h12345678, 32'h9ABCDEF0, 1'b1},
        {32'hDEADBEEF, 32'h01234567, 1'b0},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
        {32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0},
        {32'h80000000, 32'h80000000, 1'b0},
        {32'h0F0F0F0F, 32'hF0F0F0F1, 1'b0},
        {32'h7FFFFFFF, 32'h00000001, 1'b0},
        {32'h00000001, 32'hFFFFFFFE, 1'b1},
        {32'hC3A5963C, 32'h5A3CC3A5, 1'b1},
        {32'h00FF00FF, 32'h00FF00FF, 1'b1}
    };

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk_one(string tag, string who, int n, logic [31:0] got_s, logic got_c);
        longint unsigned m, full, exp_s, exp_c;
        m     = (64'd1 << n) - 1;
        full  = (longint'(ta) & m) + (longint'(tb) & m) + longint'(tc);
        exp_s = full & m;
        exp_c = (full >> n) & 1;
        checks++;
        if (longint'(got_s) != exp_s || longint'(got_c) != exp_c) begin
            errors++;
            $display("FAIL %s %s a=%h b=%h ci=%0d got=%0d:%h exp=%0d:%h",
                     tag, who, ta, tb, tc, got_c, got_s, exp_c, exp_s);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic c, string tag);
        @(posedge clk);
        ta = a; tb = b; tc = c;
        @(negedge clk);
        chk_one(tag,  "uut",     32, s_main,      c_main);
        chk_one("R6", "uut_ks",  8,  32'(s_ks),   c_ks);
        chk_one("R6", "uut_pw",  16, 32'(s_pw),   c_pw);
        chk_one("R8", "uut_odd", 20, 32'(s_odd),  c_odd);
        chk_one("R7", "uut_rip", 12, 32'(s_rip),  c_rip);
    endtask

    task automatic chk_int(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog got=hung exp=finished");
            print_summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R9 quiet state: zero inputs give zero outputs
        apply(32'h0, 32'h0, 1'b0, "R9");

        // R2 width rule
        chk_int("R2", "ks 32/7",  ks_width(32, 7),    16);
        chk_int("R2", "lo 32/7",  cs_lo_width(32, 7), 4);
        chk_int("R2", "hi 32/7",  cs_hi_width(32, 7), 5);
        chk_int("R2", "ks 20/1",  ks_width(20, 1),    16);
        chk_int("R2", "lo 20/1",  cs_lo_width(20, 1), 1);
        chk_int("R2", "hi 20/1",  cs_hi_width(20, 1), 2);
        chk_int("R2", "ks 8/3",   ks_width(8, 3),     5);
        chk_int("R2", "lo 8/3",   cs_lo_width(8, 3),  0);
        chk_int("R2", "hi 8/3",   cs_hi_width(8, 3),  0);

        // R1 vector table
        for (int i = 0; i < NV; i++)
            apply(VEC[i][64:33], VEC[i][32:1], VEC[i][0], "R1");

        // R3 full-length carry chain
        apply(32'hFFFFFFFF, 32'h00000000, 1'b1, "R3");
        apply(32'hFFFFFFFF, 32'h00000001, 1'b0, "R3");

        // R4 alternating propagate-only patterns
        apply(32'hAAAAAAAA, 32'h55555555, 1'b0, "R4");
        apply(32'hAAAAAAAA, 32'h55555555, 1'b1, "R4");

        // R5 carry stopping below, or crossing into, the select segments (bit 23 and bit 27)
        apply(32'h007FFFFF, 32'h00000000, 1'b1, "R5");
        apply(32'h00400000, 32'h00400000, 1'b0, "R5");
        apply(32'h07FFFFFF, 32'h00000001, 1'b0, "R5");
        apply(32'hF7800000, 32'h00800000, 1'b0, "R5");

        // R1 pseudo-random spread
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 64; i++) begin
            logic [31:0] ra, rb;
            seed = seed * 32'd1664525 + 32'd1013904223;
            ra = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            rb = seed;
            apply(ra, rb, seed[16], "R1");
        end

        done = 1'b1;
        print_summary();
        $finish;
    end
endmodule